// File: doc/BRIEF.md
# Watchdog Timer with Locked Configuration

This block is a watchdog for a small controller. It counts ticks of a slow oscillator, which arrive as single-cycle enable pulses in the system clock domain. A binary prescaler counts those ticks, and a 4-bit period select picks which prescaler tap ends the time-out. When the chosen time-out runs out, the block does one of two things, depending on a mode bit. It can send a one-cycle system reset pulse. It can instead set a sticky interrupt flag, which is useful for waking a sleeping core. Software restarts the count with a clear input.

A fixed strap input selects one of two protection levels. At the relaxed level the watchdog starts disabled. Software may switch it on at any time, but it may switch it off only through a timed unlock. At the strict level the watchdog cannot be switched off at all, and changing the period needs the timed unlock. The unlock is a write that sets both the change bit and the enable bit. It must be followed within a short window of clock cycles by one write that carries the new fields and has the change bit clear. If that write does not arrive in time, the window closes by itself.

The whole programming interface is a single 8-bit control register with a write strobe and continuous readback.

Top module: `wdog_guard`

## Requirements
- R1: The register layout is: bit 7 interrupt flag, bit 6 interrupt mode, bit 5 change (window open on read), bit 4 enable, bits 3:0 period select. After reset, the enable bit equals the strap (0 relaxed, 1 strict), and every other field reads 0. After reset, `irq` and `sys_rst` are low.
- R2: At the relaxed level (strap 0), any write with bit 4 set turns the enable on with no unlock. A write with bit 4 clear while no window is open leaves the enable unchanged. A period select written at this level always takes effect.
- R3: At the strict level (strap 1), the enable bit always reads 1. A period select written while no window is open is ignored.
- R4: A write with bits 5 and 4 both set opens the unlock window, and bit 5 then reads 1. A write with bit 5 clear, made on any of the next WIN (default 4) clock edges, is a completion write. At the relaxed level it loads the enable from bit 4. At both levels it loads the period select. It also closes the window.
- R5: If no completion write arrives, the window closes by itself after WIN clock edges and bit 5 reads 0. Any later write with bit 5 clear is then treated as if no window had been opened.
- R6: With period select s, let n = TAP_LO + min(s, 9), where TAP_LO defaults to 11. The watchdog expires on the tick at which the tick count since the last restart, taken modulo 2^n, reaches 2^n−1. So from a fresh restart it expires after exactly 2^n ticks. Select values 10 to 15 act as 9.
- R7: In reset mode (bit 6 = 0), an expiry gives a `sys_rst` pulse exactly one cycle wide, in the cycle after the expiring tick edge. The count then restarts from zero.
- R8: In interrupt mode (bit 6 = 1), an expiry sets the flag (bit 7), and `irq` follows the flag. The flag stays set until software writes 1 to bit 7. Writing 0 to bit 7 has no effect.
- R9: A `wd_clear` pulse sets the count to zero and takes priority over a tick in the same cycle. While the watchdog is disabled, the count is held at zero and no expiry occurs.
- R10: The count advances only on cycles with `osc_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| safe_hi | input | 1 | Protection level strap, 0 relaxed, 1 strict |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register readback |
| wd_clear | input | 1 | Restart the time-out count |
| osc_tick | input | 1 | One-cycle pulse per slow oscillator period |
| irq | output | 1 | Time-out interrupt (sticky flag) |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The bench keeps a cycle model of the register rules and of the tick count, and compares the readback, `irq` and `sys_rst` with that model on every cycle. Directed cases place the completion write on the last edge of the window and on the first edge after it, which separates a correct window length from one that is off by one. They also cover disabling without an unlock, changing the period outside the window at the strict level, and counting a reserved select value out to its full length. Random writes come biased toward unlock pairs and short periods, and they are mixed with random tick gaps and clear pulses. This exercises expiry while the period changes, clears that coincide with ticks, and flag clears that race with a new expiry, at both levels.

// File: rtl/wdog_pkg.sv
// Shared register layout and field types for the watchdog.
// Assumes a single 8-bit control register; bit positions are fixed here.
package wdog_pkg;
    localparam int REG_W   = 8;
    localparam int SEL_W   = 4;
    localparam int B_FLAG  = 7;
    localparam int B_MODE  = 6;
    localparam int B_CHG   = 5;
    localparam int B_EN    = 4;
    localparam int N_TAPS  = 10;

    typedef struct packed {
        logic             flag;
        logic             mode;
        logic             en;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_window.sv
// Unlock window tracker: an unlock write loads a down-counter, and the
// window stays open while the counter is non-zero.
// Assumes unlock_hit and done are never high together.
module wdog_window #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_hit,
    input  logic done,
    output logic win_open
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] left_q;

    // Load on unlock, drop on completion, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (unlock_hit)
            left_q <= CW'(WIN);
        else if (done)
            left_q <= '0;
        else if (left_q != '0)
            left_q <= left_q - CW'(1);
    end

    assign win_open = (left_q != '0);
endmodule

// File: rtl/wdog_presc.sv
// Tick prescaler with tap selection: counts slow ticks and flags expiry
// when the low n bits of the count are all ones on a tick.
// Assumes tick is a one-cycle enable in the clk domain.
module wdog_presc #(
    parameter int TAP_LO = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      clr,
    input  logic                      tick,
    input  logic [wdog_pkg::SEL_W-1:0] sel,
    output logic                      expire
);
    import wdog_pkg::*;

    localparam int CNT_W = TAP_LO + N_TAPS - 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [N_TAPS-1:0] tap_full;
    logic [SEL_W-1:0]  sel_eff;
    logic              tap_hit;

    // One all-ones detector per selectable period.
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        assign tap_full[i] = &cnt_q[TAP_LO+i-1:0];
    end

    // Reserved select codes fold onto the longest period.
    always_comb begin
        sel_eff = (sel > SEL_W'(N_TAPS - 1)) ? SEL_W'(N_TAPS - 1) : sel;
    end

    // Tap multiplexer.
    always_comb begin
        tap_hit = 1'b0;
        for (int k = 0; k < N_TAPS; k++)
            if (sel_eff == SEL_W'(k))
                tap_hit = tap_full[k];
    end

    assign expire = run & tick & ~clr & tap_hit;

    // Count ticks; hold at zero when stopped, cleared or expired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || clr || expire)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/wdog_cfg.sv
// Control register fields and protection rules for both strap levels,
// plus the expiry response (reset pulse or sticky flag).
// Assumes the strap only changes while rst_n is low.
module wdog_cfg (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        safe_hi,
    input  logic                        wr_en,
    input  logic [wdog_pkg::REG_W-1:0]  wr_data,
    input  logic                        win_open,
    input  logic                        expire,
    output logic                        unlock_hit,
    output logic                        done,
    output wdog_pkg::wd_cfg_t           cfg,
    output logic                        rst_pulse
);
    import wdog_pkg::*;

    wd_cfg_t cfg_q;
    logic    rst_q;
    logic    w_chg, w_en;

    assign w_chg      = wr_data[B_CHG];
    assign w_en       = wr_data[B_EN];
    assign unlock_hit = wr_en & w_chg & w_en;
    assign done       = wr_en & ~w_chg & win_open;

    // Enable bit: strict level pins it high, relaxed level gates clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.en <= safe_hi;
        else if (safe_hi)
            cfg_q.en <= 1'b1;
        else if (done)
            cfg_q.en <= w_en;
        else if (wr_en && w_en)
            cfg_q.en <= 1'b1;
    end

    // Period select: free at relaxed level, window-only at strict level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.sel <= '0;
        else if (done || (wr_en && !safe_hi))
            cfg_q.sel <= wr_data[SEL_W-1:0];
    end

    // Expiry mode bit is unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.mode <= 1'b0;
        else if (wr_en)
            cfg_q.mode <= wr_data[B_MODE];
    end

    // Sticky interrupt flag; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.flag <= 1'b0;
        else if (expire && cfg_q.mode)
            cfg_q.flag <= 1'b1;
        else if (wr_en && wr_data[B_FLAG])
            cfg_q.flag <= 1'b0;
    end

    // One-cycle reset request on expiry in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_q <= 1'b0;
        else
            rst_q <= expire & ~cfg_q.mode;
    end

    assign cfg       = cfg_q;
    assign rst_pulse = rst_q;
endmodule

// File: rtl/wdog_guard.sv
// Watchdog top: joins the register rules, the unlock window and the
// prescaler. Assumes osc_tick is already synchronous to clk.
module wdog_guard #(
    parameter int TAP_LO = 11,
    parameter int WIN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       safe_hi,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       wd_clear,
    input  logic       osc_tick,
    output logic       irq,
    output logic       sys_rst
);
    import wdog_pkg::*;

    wd_cfg_t cfg;
    logic    unlock_hit, done, win_open, expire, rst_pulse;

    wdog_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .safe_hi    (safe_hi),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .win_open   (win_open),
        .expire     (expire),
        .unlock_hit (unlock_hit),
        .done       (done),
        .cfg        (cfg),
        .rst_pulse  (rst_pulse)
    );

    wdog_window #(.WIN(WIN)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_hit (unlock_hit),
        .done       (done),
        .win_open   (win_open)
    );

    wdog_presc #(.TAP_LO(TAP_LO)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg.en),
        .clr    (wd_clear),
        .tick   (osc_tick),
        .sel    (cfg.sel),
        .expire (expire)
    );

    // Readback view of the control register.
    always_comb begin
        rd_data = {cfg.flag, cfg.mode, win_open, cfg.en, cfg.sel};
    end

    assign irq     = cfg.flag;
    assign sys_rst = rst_pulse;
endmodule

// File: rtl/wdog_guard_chk.sv
// Property checker for wdog_guard, attached with bind.
module wdog_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic safe_hi,
    input logic unl_wr,
    input logic clr_wr,
    input logic rd_en,
    input logic rd_win,
    input logic irq,
    input logic sys_rst
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst); // R7
    AST_STRICT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        safe_hi |-> rd_en); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R8
    AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_win && !unl_wr) |=> !rd_win); // R5
    AST_NO_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_hi && rd_en && !rd_win && !unl_wr) |=> rd_en); // R2
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !sys_rst); // R9
endmodule

bind wdog_guard wdog_guard_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .safe_hi (safe_hi),
    .unl_wr  (wr_en & wr_data[5] & wr_data[4]),
    .clr_wr  (wr_en & wr_data[7]),
    .rd_en   (rd_data[4]),
    .rd_win  (rd_data[5]),
    .irq     (irq),
    .sys_rst (sys_rst)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    localparam int TAP = 4;
    localparam int WN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       safe_hi = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wd_clear = 1'b0;
    logic       osc_tick = 1'b0;
    logic [7:0] rd_data;
    logic       irq, sys_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model state
    logic m_en, m_mode, m_flag, m_rst;
    logic [3:0] m_sel;
    int m_win, m_cnt;

    always #2.5 clk = ~clk;

    wdog_guard #(.TAP_LO(TAP), .WIN(WN)) u_dut (
        .clk(clk), .rst_n(rst_n), .safe_hi(safe_hi), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wd_clear(wd_clear),
        .osc_tick(osc_tick), .irq(irq), .sys_rst(sys_rst)
    );

    function automatic int period_of(input logic [3:0] s);
        return 1 << (TAP + ((s > 4'd9) ? 9 : int'(s)));
    endfunction

    function automatic logic [7:0] exp_rd();
        return {m_flag, m_mode, (m_win != 0), m_en | safe_hi, m_sel};
    endfunction

    // Requirement model, stepped on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = safe_hi; m_sel = '0; m_mode = 1'b0; m_flag = 1'b0;
            m_rst = 1'b0; m_win = 0; m_cnt = 0;
        end else begin
            automatic int  lim  = period_of(m_sel);
            automatic logic on  = m_en | safe_hi;
            automatic logic ex  = on && osc_tick && !wd_clear && ((m_cnt % lim) == lim - 1);
            automatic logic unl = wr_en && wr_data[5] && wr_data[4];
            automatic logic cmp = wr_en && !wr_data[5] && (m_win != 0);
            automatic logic old_mode = m_mode;
            if (!on || wd_clear || ex) m_cnt = 0;
            else if (osc_tick) m_cnt = m_cnt + 1;
            m_rst = ex && !old_mode;
            if (ex && old_mode) m_flag = 1'b1;
            else if (wr_en && wr_data[7]) m_flag = 1'b0;
            if (wr_en) m_mode = wr_data[6];
            if (safe_hi) m_en = 1'b1;
            else if (cmp) m_en = wr_data[4];
            else if (wr_en && wr_data[4]) m_en = 1'b1;
            if (cmp || (wr_en && !safe_hi)) m_sel = wr_data[3:0];
            if (unl) m_win = WN;
            else if (cmp) m_win = 0;
            else if (m_win != 0) m_win = m_win - 1;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, then compare outputs with the model at the falling edge.
    task automatic cyc(input logic w, input logic [7:0] d, input logic c, input logic t);
        wr_en = w; wr_data = d; wd_clear = c; osc_tick = t;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wd_clear = 1'b0; osc_tick = 1'b0;
        chk("R2 R3 R4 R5 readback", rd_data, exp_rd());
        chk("R8 irq", {7'd0, irq}, {7'd0, m_flag});
        chk("R7 sys_rst", {7'd0, sys_rst}, {7'd0, m_rst});
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0; safe_hi = lvl;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset readback", rd_data, {3'b000, lvl, 4'h0});
        chk("R1 reset outputs", {6'd0, irq, sys_rst}, 8'h00);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] rnd_wr();
        logic [7:0] d = 8'($urandom);
        if ($urandom % 4 == 0) begin d[5] = 1'b1; d[4] = 1'b1; end
        if ($urandom % 4 != 0) d[3:0] = 4'($urandom % 3);
        if ($urandom % 3 == 0) d[7] = 1'b0;
        return d;
    endfunction

    task automatic rnd_phase(input int n);
        for (int i = 0; i < n; i++)
            cyc(($urandom % 6) == 0, rnd_wr(), ($urandom % 80) == 0, ($urandom % 3) != 0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));

        // ---- relaxed level ----
        do_reset(1'b0);
        idle(2);
        cyc(1'b1, 8'h10, 1'b0, 1'b0);
        chk("R2 enable set freely", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b1, 8'h01, 1'b0, 1'b0);
        chk("R2 clear ignored without window", rd_data, 8'h11);
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        chk("R4 window reads open", {7'd0, rd_data[5]}, 8'h01);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R4 disable via unlock", rd_data, 8'h00);
        // completion on the last window edge is accepted
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        idle(WN - 1);
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        chk("R4 last-edge completion", rd_data, 8'h02);
        // one edge late is rejected
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        idle(WN);
        chk("R5 window closed", {7'd0, rd_data[5]}, 8'h00);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R5 late write ignored", {7'd0, rd_data[4]}, 8'h01);

        // reset-mode expiry after 2^TAP ticks
        cyc(1'b1, 8'h10, 1'b1, 1'b0);
        for (int i = 0; i < (1 << TAP) - 1; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 no early expiry", {7'd0, sys_rst}, 8'h00);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 pulse on last tick", {7'd0, sys_rst}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R7 pulse one cycle", {7'd0, sys_rst}, 8'h00);
        idle(20);
        chk("R10 no count without ticks", {7'd0, sys_rst}, 8'h00);

        // clear has priority over tick
        for (int i = 0; i < 10; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 1'b1, 1'b1);
        for (int i = 0; i < (1 << TAP) - 1; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R9 clear restarts count", {7'd0, sys_rst}, 8'h00);

        // interrupt mode, sticky flag, W1C
        cyc(1'b1, 8'h50, 1'b1, 1'b0);
        for (int i = 0; i < (1 << TAP); i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R8 flag set", {6'd0, irq, sys_rst}, 8'h02);
        cyc(1'b1, 8'h50, 1'b0, 1'b0);
        chk("R8 write 0 keeps flag", {7'd0, irq}, 8'h01);
        cyc(1'b1, 8'hD0, 1'b0, 1'b0);
        chk("R8 write 1 clears flag", {7'd0, irq}, 8'h00);

        // reserved select behaves as 9
        cyc(1'b1, 8'h5C, 1'b1, 1'b0);
        for (int i = 0; i < period_of(4'd9) - 1; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 reserved select not early", {7'd0, irq}, 8'h00);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 reserved select = longest", {7'd0, irq}, 8'h01);

        // disabled watchdog never expires
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        cyc(1'b1, 8'h80, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R9 disabled stays quiet", {6'd0, irq, sys_rst}, 8'h00);

        rnd_phase(8000);

        // ---- strict level ----
        do_reset(1'b1);
        cyc(1'b1, 8'h03, 1'b0, 1'b0);
        chk("R3 period locked, enable forced", rd_data, 8'h10);
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        chk("R4 period changed in window", rd_data, 8'h12);
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        idle(WN);
        cyc(1'b1, 8'h01, 1'b0, 1'b0);
        chk("R5 strict late write ignored", rd_data, 8'h12);

        rnd_phase(8000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule